// File: doc/BRIEF.md
# Dual-Enable Static RAM Model

This block is a synthesizable, clock-sampled stand-in for a byte-wide asynchronous static RAM. It is meant to sit opposite a memory controller in simulation or on an emulation fabric. The clock is a sampling clock only. On every rising edge the model samples the address, write data and four control pins. From them it decodes whether the part is deselected, writing, doing a hidden read or doing a visible read. It then updates its storage and timing state.

Two enables select the part: one is active low and one is active high. Writes take priority over the output enable. A write commits when it ends, and the byte stored is the last data value sampled while the write was active. A read drives its data only after `ACC_LAT` sampling cycles during which the address and the selection have both held steady. Any address change, or a fresh selection, restarts that wait.

There are no tri-state pins. The block gives a data-out bus and a per-bit drive-enable vector, so a bench can detect bus contention on the controller side. The default `ADDR_W` of 11 keeps the elaborated array small. Set `ADDR_W` to 13 for the full 8192 x 8 part.

Top module: `dual_ce_sram_model`

## Requirements
- R1: The part is selected only when `en_lo_n`=0 and `en_hi`=1. While it is not selected, `drive_en` is 0 on the next cycle and no write reaches storage.
- R2: Selected with `we_n`=0 is a write cycle whatever `oe_n` is. `drive_en` stays 0 on the cycle after any sampled write.
- R3: A write ends at the first sampled edge where any of these holds: `we_n` is 1, `en_lo_n` is 1, `en_hi` is 0, or the address differs from the write's address. The byte stored at the write's address is the last `din` sampled while the write was active.
- R4: Selected with `we_n`=1 and `oe_n`=0 at a steady address is a read. After the `ACC_LAT`-th sampled edge, `drive_en` is all ones and `dout` holds the stored byte. After `ACC_LAT`-1 edges, `drive_en` is still 0.
- R5: Selected with `we_n`=1 and `oe_n`=1 is a hidden read: it keeps timing but never drives. If `oe_n` falls once the data is ready, the output drives after the next edge.
- R6: While the part is selected, an address change restarts the access wait. `drive_en` is 0 from the next edge until `ACC_LAT` edges have been sampled at the new address (checked on-cycle when `ACC_LAT`>1).
- R7: Deselecting for one cycle and then reselecting restarts the access wait in full.
- R8: All bits of `drive_en` are equal. `dout` is all zeros whenever `drive_en` is 0.
- R9: While `rst_n`=0 (synchronous, active low), `drive_en` and `dout` are 0 after the next edge. A write still open when reset is sampled is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the controller |
| en_lo_n | input | 1 | Active-low chip enable |
| en_hi | input | 1 | Active-high chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| dout | output | DATA_W | Read data, zero when not driving |
| drive_en | output | DATA_W | Per-bit output drive indicator |

## Verification
The checker covers the properties that hold on every cycle. These are: silence after deselection, after a write, after a high output enable and after reset; uniform drive bits; a zero bus when idle; and no drive on the edge after an address change. Data integrity can only be shown by the bench's scenarios. This covers which byte lands where when a write closes on each of its four ending conditions, the exact cycle where read data first appears, and the discarding of a write cut by reset.

// File: rtl/dcsram_pkg.sv
package dcsram_pkg;
   typedef enum logic [1:0] {
      CYC_OFF      = 2'd0,
      CYC_WRITE    = 2'd1,
      CYC_READ_INT = 2'd2,
      CYC_READ_OUT = 2'd3
   } cyc_e;
endpackage

// File: rtl/dcsram_decode.sv
module dcsram_decode
   import dcsram_pkg::*;
(
   input  logic en_lo_n,
   input  logic en_hi,
   input  logic we_n,
   input  logic oe_n,
   output cyc_e cyc
);
   logic picked;
   assign picked = !en_lo_n && en_hi;

   always_comb begin
      if (!picked)    cyc = CYC_OFF;
      else if (!we_n) cyc = CYC_WRITE;
      else if (oe_n)  cyc = CYC_READ_INT;
      else            cyc = CYC_READ_OUT;
   end
endmodule

// File: rtl/dcsram_wr_latch.sv
module dcsram_wr_latch
   import dcsram_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              commit,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data
);
   logic              pend_q;
   logic [ADDR_W-1:0] pa_q;
   logic [DATA_W-1:0] pd_q;
   logic              active;

   assign active      = (cyc == CYC_WRITE);
   assign commit      = rst_n && pend_q && !(active && (addr == pa_q));
   assign commit_addr = pa_q;
   assign commit_data = pd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pa_q   <= '0;
         pd_q   <= '0;
      end else if (active) begin
         pend_q <= 1'b1;
         pa_q   <= addr;
         pd_q   <= din;
      end else begin
         pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dcsram_lat_timer.sv
module dcsram_lat_timer
   import dcsram_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int ACC_LAT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic [ADDR_W-1:0] addr,
   output logic              ready,
   output logic [ADDR_W-1:0] addr_held
);
   localparam int CW = $clog2(ACC_LAT + 1);

   logic [CW-1:0]     cnt_q;
   logic              rd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              reading;

   assign reading   = (cyc == CYC_READ_INT) || (cyc == CYC_READ_OUT);
   assign ready     = (cnt_q == CW'(ACC_LAT));
   assign addr_held = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rd_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         rd_q   <= reading;
         addr_q <= addr;
         if (!reading)                     cnt_q <= '0;
         else if (!rd_q || addr != addr_q) cnt_q <= CW'(1);
         else if (!ready)                  cnt_q <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/dcsram_array.sv
module dcsram_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/dual_ce_sram_model.sv
module dual_ce_sram_model
   import dcsram_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 8,
   parameter int ACC_LAT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              en_lo_n,
   input  logic              en_hi,
   input  logic              we_n,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic [DATA_W-1:0] drive_en
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must lie in 1..16");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be at least 1");
      end
      if (ACC_LAT < 1) begin : g_bad_lat
         $error("ACC_LAT must be at least 1");
      end
   endgenerate

   cyc_e              cyc;
   logic              commit;
   logic [ADDR_W-1:0] commit_addr;
   logic [DATA_W-1:0] commit_data;
   logic              ready;
   logic [ADDR_W-1:0] addr_held;
   logic [DATA_W-1:0] rdata;
   logic              show_q;
   logic              drv;

   dcsram_decode u_decode (
      .en_lo_n (en_lo_n),
      .en_hi   (en_hi),
      .we_n    (we_n),
      .oe_n    (oe_n),
      .cyc     (cyc)
   );

   dcsram_wr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc         (cyc),
      .addr        (addr),
      .din         (din),
      .commit      (commit),
      .commit_addr (commit_addr),
      .commit_data (commit_data)
   );

   dcsram_lat_timer #(.ADDR_W(ADDR_W), .ACC_LAT(ACC_LAT)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc       (cyc),
      .addr      (addr),
      .ready     (ready),
      .addr_held (addr_held)
   );

   dcsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk   (clk),
      .wr    (commit),
      .waddr (commit_addr),
      .wdata (commit_data),
      .raddr (addr_held),
      .rdata (rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) show_q <= 1'b0;
      else        show_q <= (cyc == CYC_READ_OUT);
   end

   assign drv = ready && show_q;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign drive_en[b] = drv;
      assign dout[b]     = drv & rdata[b];
   end
endmodule

// File: rtl/dual_ce_sram_model_chk.sv
module dual_ce_sram_model_chk #(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 8,
   parameter int ACC_LAT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              en_lo_n,
   input logic              en_hi,
   input logic              we_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] dout,
   input logic [DATA_W-1:0] drive_en
);
   // R1
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!en_lo_n && en_hi) |=> (drive_en == '0));

   // R2
   write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_lo_n && en_hi && !we_n) |=> (drive_en == '0));

   // R5
   oe_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |=> (drive_en == '0));

   // R8
   drive_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en == '0) || (drive_en == '1));

   // R8
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en == '0) |-> (dout == '0));

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> ((drive_en == '0) && (dout == '0)));

   generate
      if (ACC_LAT > 1) begin : g_restart
         // R6
         addr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (addr != $past(addr)) |=> (drive_en == '0));
      end
   endgenerate
endmodule

bind dual_ce_sram_model dual_ce_sram_model_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_LAT(ACC_LAT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .en_lo_n  (en_lo_n),
   .en_hi    (en_hi),
   .we_n     (we_n),
   .oe_n     (oe_n),
   .dout     (dout),
   .drive_en (drive_en)
);

// File: tb/dual_ce_sram_model_tb_top.sv
module dual_ce_sram_model_tb_top;
   localparam int AW  = 11;
   localparam int DW  = 8;
   localparam int LAT = 7;

   localparam logic [AW-1:0] VA [6] = '{11'h000, 11'h7FF, 11'h155, 11'h2AA, 11'h001, 11'h400};
   localparam logic [DW-1:0] VD [6] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h5A};

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] din;
   logic          en_lo_n, en_hi, we_n, oe_n;
   logic [DW-1:0] dout, drive_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_ce_sram_model #(.ADDR_W(AW), .DATA_W(DW), .ACC_LAT(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
      .en_lo_n(en_lo_n), .en_hi(en_hi), .we_n(we_n), .oe_n(oe_n),
      .dout(dout), .drive_en(drive_en)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_idle();
      en_lo_n = 1'b1; en_hi = 1'b0; we_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic sel_on();
      en_lo_n = 1'b0; en_hi = 1'b1;
   endtask

   task automatic write_byte(logic [AW-1:0] a, logic [DW-1:0] d);
      sel_on(); addr = a; din = d; we_n = 1'b0; oe_n = 1'b0;
      tick(2);
      chk("R2 no drive while writing with oe_n low", 32'(drive_en), 32'h0);
      we_n = 1'b1;
      tick(1);
      go_idle();
      tick(1);
   endtask

   task automatic read_check(logic [AW-1:0] a, logic [DW-1:0] e, string tag);
      sel_on(); we_n = 1'b1; oe_n = 1'b0; addr = a;
      tick(LAT - 1);
      chk({tag, " R4 no drive before latency"}, 32'(drive_en), 32'h0);
      tick(1);
      chk({tag, " R4 drive after latency"}, 32'(drive_en), 32'hFF);
      chk({tag, " R4 read data"}, 32'(dout), 32'(e));
      go_idle();
      tick(1);
   endtask

   initial begin
      rst_n = 1'b0; addr = '0; din = '0;
      go_idle();
      tick(3);
      // R9 reset state
      chk("R9 reset drive_en", 32'(drive_en), 32'h0);
      chk("R9 reset dout", 32'(dout), 32'h0);
      rst_n = 1'b1;
      tick(1);

      // R2 R4 table walk
      for (int i = 0; i < 6; i++) write_byte(VA[i], VD[i]);
      for (int i = 0; i < 6; i++) read_check(VA[i], VD[i], "R4 table");

      // R1 deselected writes by each enable
      en_lo_n = 1'b1; en_hi = 1'b1; we_n = 1'b0; addr = 11'h000; din = 8'h11;
      tick(2); we_n = 1'b1; tick(1);
      en_lo_n = 1'b0; en_hi = 1'b0; we_n = 1'b0;
      tick(2); go_idle(); tick(1);
      en_lo_n = 1'b1; en_hi = 1'b1; we_n = 1'b1; oe_n = 1'b0;
      tick(LAT + 1);
      chk("R1 no drive while deselected", 32'(drive_en), 32'h0);
      go_idle(); tick(1);
      read_check(11'h000, 8'hA5, "R1 deselected write ignored");

      // R3 write ended by low-active enable rising, last data wins
      sel_on(); we_n = 1'b0; addr = 11'h010; din = 8'h12;
      tick(1); din = 8'h34; tick(1);
      en_lo_n = 1'b1; tick(1); go_idle(); tick(1);
      read_check(11'h010, 8'h34, "R3 end by en_lo_n");

      // R3 write ended by high-active enable falling
      sel_on(); we_n = 1'b0; addr = 11'h011; din = 8'h56;
      tick(1); din = 8'h78; tick(1);
      en_hi = 1'b0; tick(1); go_idle(); tick(1);
      read_check(11'h011, 8'h78, "R3 end by en_hi");

      // R3 address change during write splits it in two
      sel_on(); we_n = 1'b0; addr = 11'h020; din = 8'h9A;
      tick(1); addr = 11'h021; din = 8'hBC; tick(1);
      we_n = 1'b1; tick(1); go_idle(); tick(1);
      read_check(11'h020, 8'h9A, "R3 first half");
      read_check(11'h021, 8'hBC, "R3 second half");

      // R5 hidden read then oe_n falls
      sel_on(); we_n = 1'b1; oe_n = 1'b1; addr = 11'h155;
      tick(LAT);
      chk("R5 hidden read quiet", 32'(drive_en), 32'h0);
      tick(2);
      chk("R5 hidden read still quiet", 32'(drive_en), 32'h0);
      oe_n = 1'b0; tick(1);
      chk("R5 drive one edge after oe_n", 32'(drive_en), 32'hFF);
      chk("R5 data", 32'(dout), 32'hFF);
      go_idle(); tick(1);

      // R6 address change restarts latency
      sel_on(); we_n = 1'b1; oe_n = 1'b0; addr = 11'h2AA;
      tick(LAT);
      chk("R6 first address driving", 32'(drive_en), 32'hFF);
      addr = 11'h001; tick(1);
      chk("R6 quiet right after change", 32'(drive_en), 32'h0);
      chk("R8 dout zero when quiet", 32'(dout), 32'h0);
      tick(LAT - 2);
      chk("R6 quiet one edge early", 32'(drive_en), 32'h0);
      tick(1);
      chk("R6 new data", 32'(dout), 32'h81);
      go_idle(); tick(1);

      // R7 reselect restarts latency
      sel_on(); we_n = 1'b1; oe_n = 1'b0; addr = 11'h400;
      tick(LAT);
      chk("R7 driving before blip", 32'(drive_en), 32'hFF);
      en_hi = 1'b0; tick(1);
      chk("R7 quiet when deselected", 32'(drive_en), 32'h0);
      en_hi = 1'b1; tick(LAT - 1);
      chk("R7 quiet one edge early", 32'(drive_en), 32'h0);
      tick(1);
      chk("R7 drive after full wait", 32'(drive_en), 32'hFF);
      chk("R7 data", 32'(dout), 32'h5A);
      go_idle(); tick(1);

      // R9 reset discards open write
      sel_on(); we_n = 1'b0; addr = 11'h7FF; din = 8'hEE;
      tick(2);
      rst_n = 1'b0; go_idle(); tick(1);
      chk("R9 quiet in reset", 32'(drive_en), 32'h0);
      tick(1); rst_n = 1'b1; tick(1);
      read_check(11'h7FF, 8'h3C, "R9 open write discarded");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule